// File: doc/BRIEF.md
# Dual-Clock Mirrored RAM Window

This block is a word-organised dual-port RAM that is reachable from two sides. The system side is a Wishbone classic slave running on the bus clock. The other side is a core-side port with its own clock, which may be unrelated to the bus clock. Both sides can read the memory and write it one byte lane at a time. A parameter can make the core side read-only, whatever the bus side is allowed to do.

On the bus side, the address window is wider than the memory by `WRAP_BITS` extra word-address bits. Those bits are not decoded, so the memory appears 2^WRAP_BITS times in a row. Software running a circular buffer can then let its pointer run past the last word and still land on the first word, with no modulo step.

Neither side is a data stream, so there is no valid/ready pair. The bus side follows the classic single-acknowledge handshake, and the core side uses plain read and write strobes. The master must hold cycle and strobe until it sees the acknowledge. The core side needs no back-pressure: it completes every strobe on the next core clock edge.

Top module: `ram_window`

## Requirements
- R1: While either reset is held, and right after it is released, `bus_ack_o` is 0, `bus_dat_o` is 0 and `core_dat_o` is 0.
- R2: `bus_ack_o` rises in the cycle after a cycle in which `bus_cyc_i` and `bus_stb_i` are both high and `bus_ack_o` is low. It stays high for exactly one cycle. It never rises after a cycle without both cycle and strobe.
- R3: A bus read returns the addressed word on `bus_dat_o` in the same cycle as its acknowledge. A word written by the bus reads back unchanged.
- R4: In a bus write, `bus_sel_i[i]` enables data bits `[8i+7:8i]`. Select `1000` on a 32-bit word writes only bits 31:24. Lanes that are not selected keep their old contents.
- R5: `bus_adr_i` is a word address. Its bits at and above log2(DEPTH) are ignored, so a write at word `DEPTH+k` is read back at word `k`, and the other way round.
- R6: A word written by one port is read back unchanged by the other port.
- R7: In a core write, `core_sel_i[i]` enables data bits `[8i+7:8i]` in the same way as R4.
- R8: `core_dat_o` takes the addressed word one core clock after `core_rd_i` is high. It keeps its value in every cycle that follows a cycle with `core_rd_i` low, even while core writes take place.
- R9: When `core_rd_i` and `core_wr_i` are high in the same cycle at the same address, `core_dat_o` shows the old word. The new word is stored.
- R10: With `CORE_WRITABLE` = 0, `core_wr_i` and `core_sel_i` have no effect on the memory. A later read from either side returns the word last written by the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| bus_rst_n | input | 1 | Bus-side reset, active low |
| bus_adr_i | input | log2(DEPTH)+WRAP_BITS | Bus word address, including the mirror bits |
| bus_dat_i | input | WIDTH | Bus write data |
| bus_sel_i | input | WIDTH/8 | Bus byte-lane selects |
| bus_cyc_i | input | 1 | Bus cycle |
| bus_stb_i | input | 1 | Bus strobe |
| bus_we_i | input | 1 | Bus write (1) or read (0) |
| bus_ack_o | output | 1 | Single-cycle acknowledge |
| bus_dat_o | output | WIDTH | Bus read data, valid with the acknowledge |
| core_clk | input | 1 | Core-side clock |
| core_rst_n | input | 1 | Core-side reset, active low |
| core_addr_i | input | log2(DEPTH) | Core word address |
| core_dat_i | input | WIDTH | Core write data |
| core_sel_i | input | WIDTH/8 | Core byte-lane selects |
| core_wr_i | input | 1 | Core write strobe |
| core_rd_i | input | 1 | Core read strobe |
| core_dat_o | output | WIDTH | Core read data, one core clock after the strobe |

## Verification
A fault in the storage banks shows up at the ports as a wrong word on the first later read of the affected address. This can be a read from either side: combining the two write histories goes wrong in a way that a cross-port read exposes at once. A fault in the acknowledge register shows up one bus cycle after the request, as a missing, doubled or spurious acknowledge. A fault in the byte-lane or mirror decode appears only when the corrupted word is read again. For that reason the bench reads back every lane pattern and every mirrored alias right after writing it.

// File: rtl/ram_window_pkg.sv
package ram_window_pkg;
  localparam int unsigned LANE_BITS = 8;

  function automatic int unsigned lanes_for(input int unsigned width);
    return width / LANE_BITS;
  endfunction
endpackage

// File: rtl/ram_window_xor_lane.sv
// One byte lane stored as two banks, each written by one clock domain only.
// The stored word is the XOR of both banks; a writer stores data ^ other bank.
module ram_window_xor_lane #(
  parameter int unsigned DEPTH   = 256,
  parameter bit          B_WRITE = 1'b1,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned LB     = ram_window_pkg::LANE_BITS
) (
  input  logic          a_clk,
  input  logic          a_rst_n,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic          a_re,
  input  logic [LB-1:0] a_din,
  output logic [LB-1:0] a_dout,
  input  logic          b_clk,
  input  logic          b_rst_n,
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic          b_re,
  input  logic [LB-1:0] b_din,
  output logic [LB-1:0] b_dout
);
  logic [LB-1:0] bank_a [DEPTH];
  logic [LB-1:0] b_at_a;
  logic [LB-1:0] b_at_b;

  always_ff @(posedge a_clk) begin
    if (a_we) bank_a[a_addr] <= a_din ^ b_at_a;
  end

  generate
    if (B_WRITE) begin : g_bank_b
      logic [LB-1:0] bank_b [DEPTH];
      always_ff @(posedge b_clk) begin
        if (b_we) bank_b[b_addr] <= b_din ^ bank_a[b_addr];
      end
      assign b_at_a = bank_b[a_addr];
      assign b_at_b = bank_b[b_addr];
    end else begin : g_no_bank_b
      logic unused_b_write;
      assign unused_b_write = b_we ^ (^b_din);
      assign b_at_a = '0;
      assign b_at_b = '0;
    end
  endgenerate

  always_ff @(posedge a_clk or negedge a_rst_n) begin
    if (!a_rst_n)  a_dout <= '0;
    else if (a_re) a_dout <= bank_a[a_addr] ^ b_at_a;
  end

  always_ff @(posedge b_clk or negedge b_rst_n) begin
    if (!b_rst_n)  b_dout <= '0;
    else if (b_re) b_dout <= bank_a[b_addr] ^ b_at_b;
  end

  AST_BUS_DOUT_HOLD: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    !a_re |=> $stable(a_dout)); // R3
  AST_CORE_DOUT_HOLD: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    !b_re |=> $stable(b_dout)); // R8
endmodule

// File: rtl/ram_window_bus_port.sv
// Wishbone classic slave front end: request qualification, ack, decode.
module ram_window_bus_port #(
  parameter int unsigned AW        = 8,
  parameter int unsigned WRAP_BITS = 1,
  parameter int unsigned LANES     = 4,
  localparam int unsigned BUS_AW   = AW + WRAP_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] adr_i,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [LANES-1:0]  sel_i,
  output logic              ack_o,
  output logic [AW-1:0]     word_addr_o,
  output logic [LANES-1:0]  lane_we_o,
  output logic              rd_en_o
);
  logic ack_q;
  logic req;

  assign req = cyc_i & stb_i & ~ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= req;
  end

  assign ack_o       = ack_q;
  assign word_addr_o = adr_i[AW-1:0];
  assign lane_we_o   = {LANES{req & we_i}} & sel_i;
  assign rd_en_o     = req & ~we_i;

  generate
    if (WRAP_BITS > 0) begin : g_mirror
      logic [WRAP_BITS-1:0] unused_mirror_bits;
      assign unused_mirror_bits = adr_i[BUS_AW-1:AW];
    end
  endgenerate

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_i && stb_i && !ack_o) |=> ack_o); // R2
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o); // R2
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_i && stb_i) |=> !ack_o); // R2
endmodule

// File: rtl/ram_window.sv
module ram_window #(
  parameter int unsigned DEPTH         = 256,
  parameter int unsigned WIDTH         = 32,
  parameter int unsigned WRAP_BITS     = 1,
  parameter bit          CORE_WRITABLE = 1'b1,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned BUS_AW = AW + WRAP_BITS,
  localparam int unsigned LANES  = ram_window_pkg::lanes_for(WIDTH)
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic [BUS_AW-1:0] bus_adr_i,
  input  logic [WIDTH-1:0]  bus_dat_i,
  input  logic [LANES-1:0]  bus_sel_i,
  input  logic              bus_cyc_i,
  input  logic              bus_stb_i,
  input  logic              bus_we_i,
  output logic              bus_ack_o,
  output logic [WIDTH-1:0]  bus_dat_o,
  input  logic              core_clk,
  input  logic              core_rst_n,
  input  logic [AW-1:0]     core_addr_i,
  input  logic [WIDTH-1:0]  core_dat_i,
  input  logic [LANES-1:0]  core_sel_i,
  input  logic              core_wr_i,
  input  logic              core_rd_i,
  output logic [WIDTH-1:0]  core_dat_o
);
  localparam int unsigned LB = ram_window_pkg::LANE_BITS;

  logic [AW-1:0]    bus_word;
  logic [LANES-1:0] bus_lane_we;
  logic             bus_rd_en;

  ram_window_bus_port #(
    .AW(AW), .WRAP_BITS(WRAP_BITS), .LANES(LANES)
  ) u_bus (
    .clk(bus_clk), .rst_n(bus_rst_n), .adr_i(bus_adr_i),
    .cyc_i(bus_cyc_i), .stb_i(bus_stb_i), .we_i(bus_we_i), .sel_i(bus_sel_i),
    .ack_o(bus_ack_o), .word_addr_o(bus_word), .lane_we_o(bus_lane_we),
    .rd_en_o(bus_rd_en)
  );

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      ram_window_xor_lane #(.DEPTH(DEPTH), .B_WRITE(CORE_WRITABLE)) u_lane (
        .a_clk(bus_clk), .a_rst_n(bus_rst_n), .a_addr(bus_word),
        .a_we(bus_lane_we[i]), .a_re(bus_rd_en),
        .a_din(bus_dat_i[i*LB +: LB]), .a_dout(bus_dat_o[i*LB +: LB]),
        .b_clk(core_clk), .b_rst_n(core_rst_n), .b_addr(core_addr_i),
        .b_we(core_wr_i & core_sel_i[i]), .b_re(core_rd_i),
        .b_din(core_dat_i[i*LB +: LB]), .b_dout(core_dat_o[i*LB +: LB])
      );
    end
  endgenerate

  AST_ACK_IDLE_AFTER_RESET: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $rose(bus_rst_n) |-> !bus_ack_o); // R1
endmodule

// File: tb/ram_window_tb.sv
module ram_window_tb;
  localparam int AW = 8;
  localparam int BAW = 9;

  logic bclk = 1'b0, cclk = 1'b0;
  always #10 bclk = ~bclk;
  always #15 cclk = ~cclk;

  logic brst_n = 1'b0, crst_n = 1'b0;
  logic [BAW-1:0] adr = '0;
  logic [31:0] dat_i = '0;
  logic [3:0]  sel = '0;
  logic cyc = 0, stb_m = 0, stb_r = 0, we = 0;
  logic ack_m, ack_r;
  logic [31:0] dat_m, dat_r;
  logic [AW-1:0] caddr = '0;
  logic [31:0] cdin = '0;
  logic [3:0]  csel = '0;
  logic cwr = 0, crd = 0;
  logic [31:0] cdout_m, cdout_r;

  ram_window u_dut (
    .bus_clk(bclk), .bus_rst_n(brst_n), .bus_adr_i(adr), .bus_dat_i(dat_i),
    .bus_sel_i(sel), .bus_cyc_i(cyc), .bus_stb_i(stb_m), .bus_we_i(we),
    .bus_ack_o(ack_m), .bus_dat_o(dat_m),
    .core_clk(cclk), .core_rst_n(crst_n), .core_addr_i(caddr), .core_dat_i(cdin),
    .core_sel_i(csel), .core_wr_i(cwr), .core_rd_i(crd), .core_dat_o(cdout_m));

  ram_window #(.DEPTH(16), .WIDTH(32), .WRAP_BITS(0), .CORE_WRITABLE(1'b0)) u_ro (
    .bus_clk(bclk), .bus_rst_n(brst_n), .bus_adr_i(adr[3:0]), .bus_dat_i(dat_i),
    .bus_sel_i(sel), .bus_cyc_i(cyc), .bus_stb_i(stb_r), .bus_we_i(we),
    .bus_ack_o(ack_r), .bus_dat_o(dat_r),
    .core_clk(cclk), .core_rst_n(crst_n), .core_addr_i(caddr[3:0]), .core_dat_i(cdin),
    .core_sel_i(csel), .core_wr_i(cwr), .core_rd_i(crd), .core_dat_o(cdout_r));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_op(input bit ro, input bit w, input logic [BAW-1:0] a,
                        input logic [3:0] s, input logic [31:0] d, output logic [31:0] rd);
    @(negedge bclk);
    adr = a; dat_i = d; sel = s; we = w; cyc = 1;
    if (ro) stb_r = 1; else stb_m = 1;
    @(negedge bclk);
    check("R2 ack one cycle after request", {31'd0, ro ? ack_r : ack_m}, 32'd1);
    rd = ro ? dat_r : dat_m;
    cyc = 0; stb_m = 0; stb_r = 0; we = 0;
    @(negedge bclk);
    check("R2 ack lasts one cycle", {31'd0, ro ? ack_r : ack_m}, 32'd0);
  endtask

  task automatic core_op(input bit w, input bit r, input logic [AW-1:0] a,
                         input logic [3:0] s, input logic [31:0] d);
    @(negedge cclk);
    caddr = a; cdin = d; csel = s; cwr = w; crd = r;
    @(negedge cclk);
    cwr = 0; crd = 0;
  endtask

  // {write, address[8:0], select[3:0], data or expected[31:0]}
  localparam int NV = 16;
  localparam logic [45:0] VEC [NV] = '{
    {1'b1, 9'h000, 4'hF, 32'hDEADBEEF},
    {1'b1, 9'h001, 4'hF, 32'hCAFECAFE},
    {1'b1, 9'h080, 4'hF, 32'hFACEDEAD},
    {1'b0, 9'h000, 4'hF, 32'hDEADBEEF},
    {1'b0, 9'h001, 4'hF, 32'hCAFECAFE},
    {1'b0, 9'h080, 4'hF, 32'hFACEDEAD},
    {1'b1, 9'h000, 4'h8, 32'h11223344},
    {1'b0, 9'h000, 4'hF, 32'h11ADBEEF},
    {1'b1, 9'h001, 4'h1, 32'h00000077},
    {1'b0, 9'h001, 4'hF, 32'hCAFECA77},
    {1'b1, 9'h104, 4'hF, 32'hA5A5A5A5},
    {1'b0, 9'h004, 4'hF, 32'hA5A5A5A5},
    {1'b0, 9'h104, 4'hF, 32'hA5A5A5A5},
    {1'b1, 9'h010, 4'hF, 32'h55555555},
    {1'b1, 9'h110, 4'hF, 32'hAAAAAAAA},
    {1'b0, 9'h010, 4'hF, 32'hAAAAAAAA}
  };

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge bclk);
    check("R1 ack in reset", {31'd0, ack_m}, 32'd0);
    check("R1 bus data in reset", dat_m, 32'd0);
    check("R1 core data in reset", cdout_m, 32'd0);
    brst_n = 1; crst_n = 1;
    repeat (2) @(negedge bclk);
    check("R1 ack after reset", {31'd0, ack_m}, 32'd0);

    // R3 R4 R5 vector walk
    for (int i = 0; i < NV; i++) begin
      bus_op(1'b0, VEC[i][45], VEC[i][44:36], VEC[i][35:32], VEC[i][31:0], rv);
      if (!VEC[i][45]) check($sformatf("R3 R4 R5 vector %0d", i), rv, VEC[i][31:0]);
    end

    // R2: cycle without strobe never acknowledged
    @(negedge bclk); cyc = 1;
    repeat (2) @(negedge bclk);
    check("R2 no ack without strobe", {31'd0, ack_m}, 32'd0);
    cyc = 0;

    // R6: core write, bus read; bus write, core read
    core_op(1, 0, 8'd4, 4'hF, 32'h0BADF00D);
    bus_op(1'b0, 1'b0, 9'h004, 4'hF, 32'd0, rv);
    check("R6 core write seen by bus", rv, 32'h0BADF00D);
    bus_op(1'b0, 1'b1, 9'h005, 4'hF, 32'h13579BDF, rv);
    core_op(0, 1, 8'd5, 4'h0, 32'd0);
    check("R6 bus write seen by core", cdout_m, 32'h13579BDF);

    // R8: core data holds while writing without read
    core_op(1, 0, 8'd5, 4'h2, 32'hFFFFFFFF);
    check("R8 core data holds without read", cdout_m, 32'h13579BDF);
    // R7: core byte lane 1 only
    core_op(0, 1, 8'd5, 4'h0, 32'd0);
    check("R7 core byte select", cdout_m, 32'h1357FFDF);
    bus_op(1'b0, 1'b0, 9'h105, 4'hF, 32'd0, rv);
    check("R7 core lanes via mirrored bus read", rv, 32'h1357FFDF);

    // R9: read during write at same address returns old word
    core_op(1, 0, 8'd6, 4'hF, 32'h11111111);
    core_op(1, 1, 8'd6, 4'hF, 32'h22222222);
    check("R9 read during write old data", cdout_m, 32'h11111111);
    core_op(0, 1, 8'd6, 4'h0, 32'd0);
    check("R9 new data stored", cdout_m, 32'h22222222);

    // R10: read-only core side
    bus_op(1'b1, 1'b1, 9'h002, 4'hF, 32'h600DCAFE, rv);
    core_op(1, 0, 8'd2, 4'hF, 32'h00000BAD);
    core_op(0, 1, 8'd2, 4'h0, 32'd0);
    check("R10 core write ignored (core read)", cdout_r, 32'h600DCAFE);
    bus_op(1'b1, 1'b0, 9'h002, 4'hF, 32'd0, rv);
    check("R10 core write ignored (bus read)", rv, 32'h600DCAFE);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule